// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a four-by-four key matrix. It raises one row line at a time and reads four column lines. A column reads high only when a closed key joins it to the row being driven. An external pull-down keeps every open column low. While nothing is pressed, the driven row moves on every clock. The first nonzero column reading stops the scan on the current row.

The column lines then pass through a two-flop synchroniser. After two cycles the block checks the synchronised value. A value with exactly one bit set is accepted and turned into a 4-bit key code, equal to row index times four plus column index. The code already held moves into a history register at the same time. Any other value, such as two keys in one row, is dropped and the scan starts again from row 0.

After an accepted key, the block sits out a bounce interval. It then waits until the accepted key's own column goes low. Other keys held at that moment play no part in the release. The host reads the latest code, the code before it, and the state.

Top module: `kp_scanner`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a clock edge, the block clears to: `row_out` = 4'b0001, `key_cur` = 0, `key_prev` = 0, `state_out` = 0 (idle).
- R2: In idle (`state_out` = 0) with `col_in` = 0, the driven row moves on every cycle in the order row 0, 1, 2, 3, then back to 0. Bit i of `row_out` drives row i.
- R3: In idle, a nonzero `col_in` moves the block to sync (`state_out` = 1) at the next edge. The driven row stays where it was.
- R4: The sync state lasts two cycles. It then judges the two-flop-synchronised column value. If exactly one bit is set (bit c for column c), the block sets `key_cur` = row*4 + c and moves to debounce (`state_out` = 2).
- R5: A synchronised column value that is not one-hot is discarded. `key_cur` and `key_prev` keep their values, the block goes back to idle, and row 0 is driven.
- R6: On every acceptance, `key_prev` takes the value `key_cur` held before that acceptance.
- R7: The debounce state lasts DEBOUNCE_CYCLES+1 cycles. The block then enters wait-for-release (`state_out` = 3).
- R8: In wait-for-release, the block stays put while the synchronised column bit of the accepted key is 1, whatever the other columns show. Three edges after that bit goes low at the pins, the block is back in idle, still driving the same row, and scanning resumes from there.
- R9: `key_cur` and `key_prev` change only on the edge where an accepted key leaves the sync state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_in | input | 4 | Column sense lines, active high, asynchronous |
| row_out | output | 4 | One-hot row drive, bit i drives row i |
| key_cur | output | 4 | Code of the last accepted key |
| key_prev | output | 4 | Code of the key accepted before that one |
| state_out | output | 2 | 0 idle, 1 sync, 2 debounce, 3 wait-for-release |

## Verification
The properties assume the column lines act like a real key matrix. A column reads high only while the driven row holds a pressed key, and a press or release stays put for at least the two synchroniser cycles. The bench meets this with a keypad model that derives `col_in` from the present `row_out` and a map of pressed keys. It changes that map only on falling clock edges and holds each change for many cycles. A multi-key press is built from two keys in the same row, so the frozen row really shows two columns at once.

// File: rtl/kp_pkg.sv
// Shared definitions for the keypad scanner.
// Assumes: the encoding below is visible at the state port and must stay fixed.
package kp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SYNC     = 2'd1,
        ST_DEBOUNCE = 2'd2,
        ST_RELEASE  = 2'd3
    } kp_state_t;
endpackage

// File: rtl/kp_sync.sv
// Multi-flop synchroniser for a bus of asynchronous inputs.
// Assumes: each bit is sampled on its own; the bus holds steady for longer
// than STAGES cycles, so skew between bits is tolerated.
module kp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_next
                // later flops copy the flop before them
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/kp_col_decode.sv
// Checks that a column vector is one-hot and returns the index of its set bit.
// Assumes: idx has meaning only while valid is high.
module kp_col_decode #(
    parameter int COLS  = 4,
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [COLS-1:0]  col,
    output logic             valid,
    output logic [COL_W-1:0] idx
);
    // one-hot test and index of the set bit
    always_comb begin
        valid = ($countones(col) == 1);
        idx   = '0;
        for (int i = 0; i < COLS; i++) begin
            if (col[i]) idx = COL_W'(i);
        end
    end
endmodule

// File: rtl/kp_row_ctr.sv
// Row index counter with one-hot row drive.
// Assumes: clear takes priority over advance; wraps from ROWS-1 to 0.
module kp_row_ctr #(
    parameter int ROWS  = 4,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             clear,
    output logic [ROW_W-1:0] row_idx,
    output logic [ROWS-1:0]  row_drv
);
    // row index register
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 row_idx <= '0;
        else if (advance) begin
            if (row_idx == ROW_W'(ROWS - 1)) row_idx <= '0;
            else                             row_idx <= row_idx + 1'b1;
        end
    end

    // one-hot drive from the index
    always_comb begin
        row_drv = '0;
        row_drv[row_idx] = 1'b1;
    end
endmodule

// File: rtl/kp_scanner.sv
// Keypad scanner top: row scan, capture, one-hot check, decode, key history,
// debounce and release wait on the accepted key's own column.
// Assumes: columns are active high with external pull-downs; col_in is
// asynchronous; DEBOUNCE_CYCLES >= 1.
module kp_scanner #(
    parameter int ROWS            = 4,
    parameter int COLS            = 4,
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 524288
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  col_in,
    output logic [3:0]  row_out,
    output logic [3:0]  key_cur,
    output logic [3:0]  key_prev,
    output logic [1:0]  state_out
);
    import kp_pkg::*;

    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int KEY_W = $clog2(ROWS * COLS);
    localparam int CNT_RAW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam int CNT_W = (CNT_RAW < 2) ? 2 : CNT_RAW;

    kp_state_t        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [COL_W-1:0] col_idx_q;
    logic [KEY_W-1:0] cur_q, prev_q;
    logic [COLS-1:0]  col_sync;
    logic             col_ok;
    logic [COL_W-1:0] col_idx_d;
    logic [ROW_W-1:0] row_idx;
    logic [ROWS-1:0]  row_drv;
    logic             row_adv, row_clr;

    kp_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(col_in), .q_out(col_sync)
    );

    kp_col_decode #(.COLS(COLS)) u_dec (
        .col(col_sync), .valid(col_ok), .idx(col_idx_d)
    );

    kp_row_ctr #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .advance(row_adv), .clear(row_clr),
        .row_idx(row_idx), .row_drv(row_drv)
    );

    // row counter control: scan in quiet idle, restart after a rejected press
    always_comb begin
        row_adv = (state_q == ST_IDLE) && (col_in == '0);
        row_clr = (state_q == ST_SYNC) && (cnt_q == '0) && !col_ok;
    end

    // main control: state, shared wait counter, key registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            col_idx_q <= '0;
            cur_q     <= '0;
            prev_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (col_in != '0) begin
                        state_q <= ST_SYNC;
                        cnt_q   <= CNT_W'(SYNC_STAGES - 1);
                    end
                end
                ST_SYNC: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (col_ok) begin
                        prev_q    <= cur_q;
                        cur_q     <= KEY_W'(row_idx) * KEY_W'(COLS) + KEY_W'(col_idx_d);
                        col_idx_q <= col_idx_d;
                        cnt_q     <= CNT_W'(DEBOUNCE_CYCLES);
                        state_q   <= ST_DEBOUNCE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DEBOUNCE: begin
                    if (cnt_q == '0) state_q <= ST_RELEASE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_RELEASE: begin
                    if (!col_sync[col_idx_q]) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign row_out   = row_drv;
    assign key_cur   = cur_q;
    assign key_prev  = prev_q;
    assign state_out = state_q;
endmodule

// File: rtl/kp_scanner_chk.sv
// Property checker for kp_scanner, attached by bind.
// Assumes: rst_n is held low for at least one edge at start.
module kp_scanner_chk #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int COL_W = 2,
    parameter int KEY_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [COLS-1:0]  col_in,
    input logic [ROWS-1:0]  row_out,
    input logic [KEY_W-1:0] key_cur,
    input logic [KEY_W-1:0] key_prev,
    input logic [1:0]       state_out,
    input logic [COLS-1:0]  col_sync,
    input logic [COL_W-1:0] col_idx_q
);
    logic rel_bit;
    assign rel_bit = col_sync[col_idx_q];

    // R2: quiet idle rotates the row drive by one place
    p_scan_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 2'd0 && col_in == '0) |=>
            (row_out == {$past(row_out[ROWS-2:0]), $past(row_out[ROWS-1])}));

    // R3: a press in idle freezes the row and enters sync
    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out == 2'd0 && col_in != '0) |=> (state_out == 2'd1 && $stable(row_out)));

    // R5: sync only falls back to idle on a rejected press, which restarts at row 0
    p_reject_row0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_out) == 2'd1 && state_out == 2'd0) |-> (row_out == ROWS'(1)));

    // R6: acceptance shifts the old key into history
    p_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_out) == 2'd1 && state_out == 2'd2) |-> (key_prev == $past(key_cur)));

    // R7: wait-for-release is only entered from debounce
    p_after_db_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_out) != 2'd3 && state_out == 2'd3) |-> ($past(state_out) == 2'd2));

    // R8: leaving wait-for-release needs the accepted column to be low
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_out) == 2'd3 && state_out != 2'd3) |-> ($past(rel_bit) == 1'b0 && state_out == 2'd0));

    // R9: keys hold unless the block is in sync
    p_keys_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_out != 2'd1) |=> ($stable(key_cur) && $stable(key_prev)));
endmodule

bind kp_scanner kp_scanner_chk #(
    .ROWS(ROWS), .COLS(COLS), .COL_W(COL_W), .KEY_W(KEY_W)
) u_kp_chk (
    .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_out(row_out),
    .key_cur(key_cur), .key_prev(key_prev), .state_out(state_out),
    .col_sync(col_sync), .col_idx_q(col_idx_q)
);

// File: tb/test_kp_scanner.sv
// Directed bench for kp_scanner with a keypad model driven from pressed keys.
module test_kp_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int DB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  col_in;
    logic [3:0]  row_out, key_cur, key_prev;
    logic [1:0]  state_out;
    logic [15:0] pressed = '0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // keypad model: a column is high when a pressed key sits on the driven row
    always_comb begin
        col_in = '0;
        for (int r = 0; r < 4; r++)
            if (row_out[r]) col_in = col_in | pressed[r*4 +: 4];
    end

    kp_scanner #(.DEBOUNCE_CYCLES(DB)) i_kp_scanner (
        .clk(clk), .rst_n(rst_n), .col_in(col_in), .row_out(row_out),
        .key_cur(key_cur), .key_prev(key_prev), .state_out(state_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_state(input int st, input int limit, output int n);
        n = 0;
        while (state_out != 2'(st) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(row_out == 4'b0001, "R1 row", row_out, 1);
        chk(key_cur == 0, "R1 key_cur", key_cur, 0);
        chk(key_prev == 0, "R1 key_prev", key_prev, 0);
        chk(state_out == 0, "R1 state", state_out, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_scan();
        int exp_row;
        exp_row = 0;
        for (int i = 0; i < 9; i++) begin
            chk(row_out == 4'(1 << exp_row), "R2 scan", row_out, 1 << exp_row);
            @(negedge clk);
            exp_row = (exp_row + 1) % 4;
        end
    endtask

    // press a key and follow it through sync and debounce into release wait
    task automatic t_accept(input int row, input int col, input int old_cur);
        int n;
        pressed[row*4 + col] = 1'b1;
        wait_state(1, 10, n);
        chk(state_out == 1, "R3 sync entered", state_out, 1);
        chk(row_out == 4'(1 << row), "R3 frozen row", row_out, 1 << row);
        @(negedge clk);
        chk(state_out == 1, "R4 sync second cycle", state_out, 1);
        @(negedge clk);
        chk(state_out == 2, "R4 debounce entered", state_out, 2);
        chk(key_cur == 4'(row*4 + col), "R4 key code", key_cur, row*4 + col);
        chk(key_prev == 4'(old_cur), "R6 history", key_prev, old_cur);
        n = 1;
        @(negedge clk);
        while (state_out == 2 && n < DB + 20) begin
            n++;
            @(negedge clk);
        end
        chk(n == DB + 1, "R7 debounce length", n, DB + 1);
        chk(state_out == 3, "R7 release wait", state_out, 3);
    endtask

    task automatic t_hold_release(input int row, input int col);
        int n;
        repeat (20) @(negedge clk);
        chk(state_out == 3, "R8 hold", state_out, 3);
        pressed[row*4 + col] = 1'b0;
        n = 0;
        while (state_out == 3 && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(n == 3, "R8 release latency", n, 3);
        chk(row_out == 4'(1 << row), "R8 resume row", row_out, 1 << row);
        @(negedge clk);
        chk(row_out == 4'(1 << ((row + 1) % 4)), "R8 scan resumes", row_out, 1 << ((row + 1) % 4));
    endtask

    task automatic t_multi();
        int n;
        logic [3:0] c0, p0;
        c0 = key_cur; p0 = key_prev;
        pressed[2*4 + 1] = 1'b1;
        pressed[2*4 + 3] = 1'b1;
        wait_state(1, 10, n);
        chk(state_out == 1, "R5 sync entered", state_out, 1);
        repeat (2) @(negedge clk);
        chk(state_out == 0, "R5 back to idle", state_out, 0);
        chk(row_out == 4'b0001, "R5 row0", row_out, 1);
        pressed = '0;
        chk(key_cur == c0, "R5 key_cur kept", key_cur, c0);
        chk(key_prev == p0, "R5 key_prev kept", key_prev, p0);
        repeat (6) @(negedge clk);
        chk(key_cur == c0 && state_out == 0, "R9 no change after reject", key_cur, c0);
    endtask

    task automatic t_other_col();
        int n;
        t_accept(1, 0, int'(key_cur));
        pressed[1*4 + 2] = 1'b1;
        repeat (10) @(negedge clk);
        chk(state_out == 3, "R8 other column ignored", state_out, 3);
        pressed[1*4 + 0] = 1'b0;
        wait_state(2, 20, n);
        chk(key_cur == 6, "R8 second key after own release", key_cur, 6);
        chk(key_prev == 4, "R6 history second key", key_prev, 4);
        pressed = '0;
        wait_state(0, DB + 20, n);
        chk(state_out == 0, "R8 final idle", state_out, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_scan();
        t_accept(2, 3, 0);
        t_hold_release(2, 3);
        t_accept(0, 1, 11);
        t_hold_release(0, 1);
        t_multi();
        t_accept(3, 0, 1);
        t_hold_release(3, 0);
        t_other_col();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule